// File: doc/BRIEF.md
# Serial-Loaded Multiplexed Seven-Segment Driver

A host microcontroller sends display data to this block over three plain wires: a serial clock, a serial data line and a load strobe. The block shifts the bits into a staging register. On a complete frame, a load strobe copies them into a holding register, so the panel never shows a half-written frame. Each held digit is a 4-bit hex code with a decimal-point bit and a blank bit. Each code is decoded into a seven-segment pattern.

The panel has six digits, which makes 48 LED lines. Only 24 segment outputs are provided. Digits 0–2 and digits 3–5 take turns on these lines, and each half has its own group-enable pin. A prescaler sets how long each group stays lit. With the default setting and a 100 MHz logic clock, the groups switch about every 5 ms, so the whole panel refreshes at about 100 Hz. At every switch, both enables stay low for a short guard interval. This stops one group's segment pattern from briefly lighting the other group's digits.

The serial link has no back-pressure. The host sets the pace, and the block keeps up with any serial clock that is at least a few logic clocks high and a few logic clocks low. The segment and enable pins are plain level outputs.

Top module: `seg_mux_driver`

## Requirements
- R1: A frame is 36 bits sent most significant bit first. A bit is taken on each rising edge of `ser_clk`, after a two-flop synchronizer. Digit d occupies frame bits [6d+5:6d]: the hex code in [6d+5:6d+2], the decimal point in [6d+1] and the blank flag in [6d]. Digit 5 is therefore sent first.
- R2: While bits are being shifted, the segment outputs keep showing the previously loaded frame. A rising edge of `ser_load` makes the new frame visible.
- R3: A load strobe that arrives after fewer than 36 bits since the last accepted load is ignored, and the display does not change. The bits already shifted still count toward the next load.
- R4: If more than 36 bits arrive before a load, the last 36 bits received form the frame.
- R5: Segment byte bit order is a=bit0 through g=bit6, with dp=bit7, all active-high. The codes 0–F map to 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 in hex.
- R6: A set decimal-point bit drives bit 7 of that digit's byte high. A clear bit drives it low.
- R7: A set blank flag forces all eight bits of that digit's byte to zero, whatever its code and decimal point are.
- R8: When `grp_en[0]` is high, `seg_out[8i+7:8i]` carries digit i. When `grp_en[1]` is high, it carries digit 3+i.
- R9: `grp_en[0]` and `grp_en[1]` are never high in the same cycle.
- R10: Each group phase lasts PRESCALE cycles. In the first GAP cycles (16 by default) both enables are low. For the remaining cycles only the current group's enable is high. The phases alternate between group 0 and group 1.
- R11: After synchronous reset, every digit is blank (`seg_out` is all zero). Group 0 is the first group lit, and its enable rises exactly GAP cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Asynchronous serial bit clock from the host |
| ser_data | input | 1 | Serial data, sampled on the `ser_clk` rising edge |
| ser_load | input | 1 | Load strobe; its rising edge commits a complete frame |
| seg_out | output | 24 | Segment lines for the active group, 8 bits per digit |
| grp_en | output | 2 | One-hot group enables, both low during guard gaps |

## Verification
The bench looks at the display in the middle of a frame load. A design without a holding register would show partly shifted data there. It sends a load strobe after only 10 bits and checks that nothing changes. It then finishes the frame and checks that the earlier bits counted, which catches a counter that resets on every strobe. It also sends 40 bits before a load, which catches a design that keeps the first 36 bits instead of the last. Every hex code is decoded alongside decimal-point and blank bits. Wrong field positions or blank priority would show up as wrong bytes in a specific digit slot. Over several phases, the scan is timed cycle by cycle. A missing or misplaced guard gap, an off-by-one prescaler, or group 1 coming up first after reset would each change the measured run lengths.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int FIELD_W = 6;

  typedef struct packed {
    logic [3:0] code;
    logic       dp;
    logic       blank;
  } digit_field_t;

  function automatic logic [7:0] hex_glyph(input logic [3:0] code);
    logic [6:0] g;
    case (code)
      4'h0: g = 7'h3F;
      4'h1: g = 7'h06;
      4'h2: g = 7'h5B;
      4'h3: g = 7'h4F;
      4'h4: g = 7'h66;
      4'h5: g = 7'h6D;
      4'h6: g = 7'h7D;
      4'h7: g = 7'h07;
      4'h8: g = 7'h7F;
      4'h9: g = 7'h6F;
      4'hA: g = 7'h77;
      4'hB: g = 7'h7C;
      4'hC: g = 7'h39;
      4'hD: g = 7'h5E;
      4'hE: g = 7'h79;
      default: g = 7'h71;
    endcase
    return {1'b0, g};
  endfunction

  function automatic logic [7:0] render_digit(input digit_field_t f);
    logic [7:0] s;
    s = hex_glyph(f.code);
    s[7] = f.dp;
    if (f.blank) s = 8'h00;
    return s;
  endfunction

endpackage

// File: rtl/ser_frontend.sv
module ser_frontend #(
  parameter int DIGITS = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ser_clk,
  input  logic                           ser_data,
  input  logic                           ser_load,
  output logic [DIGITS*seg_pkg::FIELD_W-1:0] hold_o
);
  localparam int FB   = DIGITS * seg_pkg::FIELD_W;
  localparam int CNTW = $clog2(FB + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(FB);
  localparam logic [FB-1:0] BLANK_INIT = {DIGITS{6'b000001}};

  logic [2:0]      ck_sr, ld_sr;
  logic [1:0]      dt_sr;
  logic [FB-1:0]   stage_q, hold_q;
  logic [CNTW-1:0] cnt_q;
  logic            bit_rise, ld_rise, commit;

  assign bit_rise = ck_sr[1] & ~ck_sr[2];
  assign ld_rise  = ld_sr[1] & ~ld_sr[2];
  assign commit   = ld_rise && (cnt_q == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sr   <= '0;
      ld_sr   <= '0;
      dt_sr   <= '0;
      stage_q <= '0;
      hold_q  <= BLANK_INIT;
      cnt_q   <= '0;
    end else begin
      ck_sr <= {ck_sr[1:0], ser_clk};
      ld_sr <= {ld_sr[1:0], ser_load};
      dt_sr <= {dt_sr[0], ser_data};
      if (bit_rise) stage_q <= {stage_q[FB-2:0], dt_sr[1]};
      if (commit) begin
        hold_q <= stage_q;
        cnt_q  <= bit_rise ? CNTW'(1) : '0;
      end else if (bit_rise && cnt_q != FULL) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

  a_r2_hold_steady: assert property (@(posedge clk) disable iff (rst)
    !ld_rise |=> $stable(hold_q));
  a_r3_short_load_ignored: assert property (@(posedge clk) disable iff (rst)
    (ld_rise && cnt_q < FULL) |=> $stable(hold_q));
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);

endmodule

// File: rtl/group_scan.sv
module group_scan #(
  parameter int PRESCALE = 500000,
  parameter int GAP      = 16
) (
  input  logic       clk,
  input  logic       rst,
  output logic       sel_o,
  output logic [1:0] grp_en
);
  localparam int CW = $clog2(PRESCALE);
  localparam logic [CW-1:0] LAST  = CW'(PRESCALE - 1);
  localparam logic [CW-1:0] GAP_C = CW'(GAP);

  logic [CW-1:0] ph_q;
  logic          sel_q;
  logic          lit;

  initial begin
    if (PRESCALE <= GAP + 1) $error("PRESCALE must exceed GAP + 1");
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      sel_q <= 1'b0;
    end else if (ph_q == LAST) begin
      ph_q  <= '0;
      sel_q <= ~sel_q;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign lit    = (ph_q >= GAP_C);
  assign grp_en = {lit & sel_q, lit & ~sel_q};
  assign sel_o  = sel_q;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(grp_en[0] && grp_en[1]));
  a_r10_gap_on_switch: assert property (@(posedge clk) disable iff (rst)
    (ph_q == LAST) |=> (grp_en == 2'b00));
  a_r10_alternate: assert property (@(posedge clk) disable iff (rst)
    (ph_q == LAST) |=> (sel_q != $past(sel_q)));

endmodule

// File: rtl/seg_group_mux.sv
module seg_group_mux #(
  parameter int DIGITS       = 6,
  parameter int GROUP_DIGITS = 3
) (
  input  logic [DIGITS*seg_pkg::FIELD_W-1:0] hold_i,
  input  logic                               sel_i,
  output logic [GROUP_DIGITS*8-1:0]          seg_o
);
  import seg_pkg::*;

  logic [7:0] glyph [DIGITS];

  for (genvar d = 0; d < DIGITS; d++) begin : g_dec
    digit_field_t f;
    assign f        = digit_field_t'(hold_i[d*FIELD_W +: FIELD_W]);
    assign glyph[d] = render_digit(f);
  end

  for (genvar i = 0; i < GROUP_DIGITS; i++) begin : g_lane
    assign seg_o[i*8 +: 8] = sel_i ? glyph[GROUP_DIGITS + i] : glyph[i];
  end

endmodule

// File: rtl/seg_mux_driver.sv
module seg_mux_driver #(
  parameter int DIGITS   = 6,
  parameter int PRESCALE = 500000,
  parameter int GAP      = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ser_clk,
  input  logic                         ser_data,
  input  logic                         ser_load,
  output logic [(DIGITS/2)*8-1:0]      seg_out,
  output logic [1:0]                   grp_en
);
  localparam int GROUP_DIGITS = DIGITS / 2;
  localparam int FB = DIGITS * seg_pkg::FIELD_W;

  logic [FB-1:0] hold;
  logic          sel;

  ser_frontend #(.DIGITS(DIGITS)) u_fe (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .hold_o(hold)
  );

  group_scan #(.PRESCALE(PRESCALE), .GAP(GAP)) u_scan (
    .clk(clk), .rst(rst), .sel_o(sel), .grp_en(grp_en)
  );

  seg_group_mux #(.DIGITS(DIGITS), .GROUP_DIGITS(GROUP_DIGITS)) u_mux (
    .hold_i(hold), .sel_i(sel), .seg_o(seg_out)
  );

endmodule

// File: tb/sim_seg_mux_driver.sv
module sim_seg_mux_driver;
  localparam int PRE = 64;
  localparam int GAP = 16;

  logic clk = 0, rst = 1, ser_clk = 0, ser_data = 0, ser_load = 0;
  logic [23:0] seg_out;
  logic [1:0]  grp_en;
  int checks = 0, errors = 0;
  logic [35:0] shown;

  always #2.5 clk = ~clk;

  seg_mux_driver #(.DIGITS(6), .PRESCALE(PRE), .GAP(GAP)) u0 (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .seg_out(seg_out), .grp_en(grp_en)
  );

  function automatic logic [7:0] exp_byte(input logic [5:0] f);
    logic [6:0] g;
    case (f[5:2])
      4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
      4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
      4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
      4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
    endcase
    return f[0] ? 8'h00 : {f[1], g};
  endfunction

  function automatic logic [35:0] mk(input logic [23:0] codes, input logic [5:0] dps,
                                     input logic [5:0] bl);
    logic [35:0] fr;
    for (int d = 0; d < 6; d++) fr[6*d +: 6] = {codes[4*d +: 4], dps[d], bl[d]};
    return fr;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; clks(3);
    ser_clk = 1;  clks(3);
    ser_clk = 0;  clks(3);
  endtask

  task automatic send_bits(input logic [35:0] fr, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) send_bit(fr[i]);
  endtask

  task automatic pulse_load;
    ser_load = 1; clks(4);
    ser_load = 0; clks(6);
  endtask

  task automatic wait_group(input int g);
    while (grp_en !== (g == 0 ? 2'b01 : 2'b10)) @(negedge clk);
  endtask

  task automatic check_display(input string req, input logic [35:0] fr);
    for (int g = 0; g < 2; g++) begin
      wait_group(g);
      for (int i = 0; i < 3; i++)
        chk(req, seg_out[8*i +: 8], exp_byte(fr[6*(3*g+i) +: 6]));
    end
  endtask

  // R11: reset state and first group
  task automatic t_reset;
    int n;
    rst = 1; clks(3); rst = 0;
    n = 0;
    while (grp_en === 2'b00 && n < 200) begin
      chk("R11 blank", seg_out, 24'h0);
      @(posedge clk); @(negedge clk); n++;
    end
    chk("R11 gap", n, GAP);
    chk("R11 group0 first", grp_en, 2'b01);
    chk("R11 blank lit", seg_out, 24'h0);
    wait_group(1);
    chk("R11 group1 blank", seg_out, 24'h0);
  endtask

  // R1 R5 R8: all hex codes across the digit slots
  task automatic t_decode;
    logic [35:0] fr;
    fr = mk(24'h543210, 6'h00, 6'h00); send_bits(fr, 35, 0); pulse_load;
    check_display("R1 R5 R8 codes 0-5", fr);
    fr = mk(24'hBA9876, 6'h00, 6'h00); send_bits(fr, 35, 0); pulse_load;
    check_display("R5 R8 codes 6-B", fr);
    fr = mk(24'h10FEDC, 6'h00, 6'h00); send_bits(fr, 35, 0); pulse_load;
    check_display("R5 R8 codes C-F", fr);
    shown = fr;
  endtask

  // R6 R7: decimal points and blanking
  task automatic t_dp_blank;
    logic [35:0] fr;
    fr = mk(24'h8F8E88, 6'b101101, 6'b010100);
    send_bits(fr, 35, 0); pulse_load;
    check_display("R6 R7 dp and blank", fr);
    wait_group(1);
    chk("R7 blank digit4", seg_out[15:8], 8'h00);
    chk("R6 dp digit5", seg_out[23], 1'b1);
    shown = fr;
  endtask

  // R2: display holds during shifting
  task automatic t_double_buffer;
    logic [35:0] fr;
    fr = mk(24'h2468AC, 6'h2A, 6'h00);
    send_bits(fr, 35, 16);
    check_display("R2 steady mid-frame", shown);
    send_bits(fr, 15, 0);
    check_display("R2 steady before load", shown);
    pulse_load;
    check_display("R2 shown after load", fr);
    shown = fr;
  endtask

  // R3: short load ignored, bits still count
  task automatic t_short_load;
    logic [35:0] fr;
    fr = mk(24'h13579B, 6'h11, 6'h00);
    send_bits(fr, 35, 26);
    pulse_load;
    check_display("R3 short load ignored", shown);
    send_bits(fr, 25, 0);
    pulse_load;
    check_display("R3 completed frame loads", fr);
    shown = fr;
  endtask

  // R4: last 36 bits win
  task automatic t_overlong;
    logic [35:0] fr;
    fr = mk(24'hFEDCBA, 6'h20, 6'h00);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    send_bits(fr, 35, 0);
    pulse_load;
    check_display("R4 last 36 bits", fr);
  endtask

  // R9 R10: scan timing
  task automatic t_scan;
    int n;
    wait_group(1);
    while (grp_en !== 2'b00) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      n = 0;
      while (grp_en === 2'b00) begin @(negedge clk); n++; end
      chk("R10 gap length", n, GAP);
      chk("R10 alternation", grp_en, (p % 2 == 0) ? 2'b01 : 2'b10);
      n = 0;
      while (grp_en !== 2'b00) begin
        if (grp_en === 2'b11) chk("R9 exclusive", grp_en, 2'b01);
        @(negedge clk); n++;
      end
      chk("R10 lit length", n, PRE - GAP);
    end
  endtask

  initial begin
    clks(2);
    t_reset;
    t_decode;
    t_dp_blank;
    t_double_buffer;
    t_short_load;
    t_overlong;
    t_scan;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule